// File: doc/BRIEF.md
# Power Controller Fault Supervisor

This block is the enable and fault state machine of an offline constant-current LED controller. It receives already-digitised comparator flags: the supply being above its turn-on level or below its turn-off level, supply over-voltage, sampled auxiliary-winding over-voltage (open LED string), a current-sense level that indicates a shorted output diode, current-sense under-voltage while the gate is off, and over-temperature with its hysteresis already applied. It also receives a per-switching-cycle strobe and the modulator's raw gate request.

From these inputs it drives three enables. The switching enable is ANDed with the modulator output outside this block. The high-voltage start-up device enable charges the supply capacitor from the line. The dimming source-current enable opens a fixed window after each turn-on. The block sequences start-up, stops switching on any fault in the same clock cycle, restarts automatically through the start-up state, and runs a thermal hiccup loop on the supply thresholds while the die is hot.

Top module: `pwr_fault_supervisor`

## Requirements
- R1: Reset puts the block in its off state with all three enables low. One clock later it is in start-up with `hv_en`=1 and `sw_en`=0. It enters run (`sw_en`=1, `hv_en`=0) on the first edge where `sup_above_on`=1 and `hot`=0.
- R2: In run, `sup_below_off`, `sup_ovp`, `aux_ovp` or `hot` being 1 drives `sw_en` low in the same clock cycle.
- R3: From run, the next state follows this priority. `sup_below_off` returns to start-up (`hv_en`=1). Otherwise `hot` enters the thermal hiccup state. Otherwise `sup_ovp` or `aux_ovp` enters fault wait (`hv_en`=0, `sw_en`=0).
- R4: Fault wait returns to start-up when `sup_ovp`, `aux_ovp` and `cs_shut` are all 0, or when `sup_below_off`=1. Run is reached again only through a turn-on crossing.
- R5: An `aux_ovp` flag that is still present when run is re-entered keeps `sw_en` low in that cycle and trips the fault again.
- R6: A `cyc_end` strobe samples `cs_shut`. The diode-short fault trips on the DSHORT_N-th consecutive strobe with `cs_shut`=1: `sw_en` goes low in that cycle and the block enters fault wait. A strobe with `cs_shut`=0 restarts the count. `cs_shut` without a strobe does not count.
- R7: `sw_en` is low while `gate_req`=0 and `cs_uvp`=1. The blocking value is held through any following `gate_req`=1 interval. It is released at the next cycle with `gate_req`=0 and `cs_uvp`=0. `cs_uvp` seen while `gate_req`=1 has no effect.
- R8: In the thermal hiccup state, `sw_en`=0. `hv_en` goes to 1 after `sup_below_off` and back to 0 after `sup_above_on`, starting at 0 on entry. When `hot` clears, the block returns to start-up.
- R9: A turn-on crossing in start-up while `hot`=1 enters the thermal hiccup state instead of run.
- R10: `dim_src_en` is 1 for exactly DIM_WIN clock cycles, beginning at the edge that sees a turn-on crossing in start-up. It is cleared early by `sup_below_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_on | input | 1 | Supply above turn-on threshold |
| sup_below_off | input | 1 | Supply below turn-off threshold |
| sup_ovp | input | 1 | Supply over-voltage |
| aux_ovp | input | 1 | Sampled auxiliary winding over-voltage |
| cs_shut | input | 1 | Current sense above diode-short level |
| cyc_end | input | 1 | One-cycle strobe per switching cycle |
| gate_req | input | 1 | Modulator gate request |
| cs_uvp | input | 1 | Current sense under-voltage |
| hot | input | 1 | Over-temperature, hysteresis applied |
| sw_en | output | 1 | Switching enable |
| hv_en | output | 1 | High-voltage start-up device enable |
| dim_src_en | output | 1 | Dimming source-current enable |

## Verification
The bench builds the block with DSHORT_N=3 and DIM_WIN=20. With these values the consecutive-strobe counter can be driven to its trip point and made to restart within a handful of cycles. The dimming window can also be counted edge by edge to its last active cycle. A sweep covers all sixteen combinations of under-voltage, supply over-voltage, auxiliary over-voltage and temperature applied in run. For each combination the bench checks the same-cycle gate enable, the next state and the restart path, each computed from the priority order.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    ST_OFF        = 3'd0,
    ST_STARTUP    = 3'd1,
    ST_RUN        = 3'd2,
    ST_FAULT_WAIT = 3'd3,
    ST_OTP_HICCUP = 3'd4
  } pfs_state_e;
endpackage

// File: rtl/pfs_dshort_cnt.sv
// Consecutive-cycle confirmation of the diode-short flag (R6)
module pfs_dshort_cnt #(
  parameter int unsigned N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cyc_end,
  input  logic cs_shut,
  output logic trip
);
  generate
    if (N <= 1) begin : g_direct
      assign trip = !clr && cyc_end && cs_shut;
    end else begin : g_count
      localparam int unsigned CW = $clog2(N);
      localparam logic [CW-1:0] LAST = CW'(N - 1);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      assign cnt_en = clr || cyc_end;

      always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
          cnt_d = '0;
        end else if (cyc_end) begin
          if (!cs_shut || cnt_q == LAST) cnt_d = '0;
          else                           cnt_d = cnt_q + CW'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign trip = !clr && cyc_end && cs_shut && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pfs_dim_timer.sv
// Post-turn-on dimming source window (R10)
module pfs_dim_timer #(
  parameter int unsigned WIN = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clr,
  output logic active
);
  localparam int unsigned TW = $clog2(WIN + 1);
  localparam logic [TW-1:0] WIN_V = TW'(WIN);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign active = (cnt_q != '0);
  assign cnt_en = load || clr || active;

  always_comb begin
    if (load)     cnt_d = WIN_V;
    else if (clr) cnt_d = '0;
    else          cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pfs_seq_fsm.sv
// Start-up, run, fault and thermal hiccup sequencing
module pfs_seq_fsm
  import pfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sup_above_on,
  input  logic sup_below_off,
  input  logic sup_ovp,
  input  logic aux_ovp,
  input  logic cs_shut,
  input  logic hot,
  input  logic dshort_trip,
  input  logic gate_req,
  input  logic cs_uvp,
  output logic sw_en,
  output logic hv_en,
  output logic in_run,
  output logic turn_on_evt
);
  pfs_state_e state_q, state_d;
  logic       chg_q, chg_d;
  logic       uvp_q;
  logic       uvp_en;
  logic       uvp_blk;
  logic       fault_now;

  assign fault_now   = sup_below_off || hot || sup_ovp || aux_ovp || dshort_trip;
  assign in_run      = (state_q == ST_RUN);
  assign turn_on_evt = (state_q == ST_STARTUP) && sup_above_on;

  // R7: the under-voltage verdict taken while the gate is off holds through the on time
  assign uvp_en  = !gate_req;
  assign uvp_blk = gate_req ? uvp_q : cs_uvp;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:     state_d = ST_STARTUP;
      ST_STARTUP: if (sup_above_on) state_d = hot ? ST_OTP_HICCUP : ST_RUN;
      ST_RUN: begin
        if (sup_below_off)                          state_d = ST_STARTUP;
        else if (hot)                               state_d = ST_OTP_HICCUP;
        else if (sup_ovp || aux_ovp || dshort_trip) state_d = ST_FAULT_WAIT;
      end
      ST_FAULT_WAIT: begin
        if (hot)
          state_d = ST_OTP_HICCUP;
        else if (sup_below_off || (!sup_ovp && !aux_ovp && !cs_shut))
          state_d = ST_STARTUP;
      end
      ST_OTP_HICCUP: if (!hot) state_d = ST_STARTUP;
      default:       state_d = ST_OFF;
    endcase
  end

  always_comb begin
    chg_d = chg_q;
    if (state_q != ST_OTP_HICCUP) chg_d = 1'b0;
    else if (sup_below_off)       chg_d = 1'b1;
    else if (sup_above_on)        chg_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      chg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      chg_q   <= chg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      uvp_q <= 1'b0;
    else if (uvp_en) uvp_q <= cs_uvp;
  end

  assign sw_en = in_run && !fault_now && !uvp_blk;
  assign hv_en = (state_q == ST_STARTUP) || ((state_q == ST_OTP_HICCUP) && chg_q);
endmodule

// File: rtl/pwr_fault_supervisor.sv
module pwr_fault_supervisor #(
  parameter int unsigned DSHORT_N = 3,
  parameter int unsigned DIM_WIN  = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_above_on,
  input  logic sup_below_off,
  input  logic sup_ovp,
  input  logic aux_ovp,
  input  logic cs_shut,
  input  logic cyc_end,
  input  logic gate_req,
  input  logic cs_uvp,
  input  logic hot,
  output logic sw_en,
  output logic hv_en,
  output logic dim_src_en
);
  logic dshort_trip;
  logic in_run;
  logic turn_on_evt;

  pfs_dshort_cnt #(.N(DSHORT_N)) u_dshort (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!in_run),
    .cyc_end (cyc_end),
    .cs_shut (cs_shut),
    .trip    (dshort_trip)
  );

  pfs_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .sup_above_on  (sup_above_on),
    .sup_below_off (sup_below_off),
    .sup_ovp       (sup_ovp),
    .aux_ovp       (aux_ovp),
    .cs_shut       (cs_shut),
    .hot           (hot),
    .dshort_trip   (dshort_trip),
    .gate_req      (gate_req),
    .cs_uvp        (cs_uvp),
    .sw_en         (sw_en),
    .hv_en         (hv_en),
    .in_run        (in_run),
    .turn_on_evt   (turn_on_evt)
  );

  pfs_dim_timer #(.WIN(DIM_WIN)) u_dim (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (turn_on_evt),
    .clr    (sup_below_off),
    .active (dim_src_en)
  );
endmodule

// File: rtl/pfs_chk.sv
module pfs_chk (
  input logic clk,
  input logic rst_n,
  input logic sup_above_on,
  input logic sup_below_off,
  input logic sup_ovp,
  input logic aux_ovp,
  input logic hot,
  input logic gate_req,
  input logic cs_uvp,
  input logic sw_en,
  input logic hv_en,
  input logic dim_src_en
);
  a_r1_hv_sw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hv_en && sw_en));

  a_r2_fault_blocks_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_below_off || sup_ovp || aux_ovp || hot) |-> !sw_en);

  a_r7_uvp_blocks_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_req && cs_uvp) |-> !sw_en);

  a_r10_dim_after_turnon: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dim_src_en) |-> $past(sup_above_on));

  a_r4_restart_through_startup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) && !$past(sw_en) && $past(hv_en) |-> $past(sup_above_on));
endmodule

bind pwr_fault_supervisor pfs_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sup_above_on  (sup_above_on),
  .sup_below_off (sup_below_off),
  .sup_ovp       (sup_ovp),
  .aux_ovp       (aux_ovp),
  .hot           (hot),
  .gate_req      (gate_req),
  .cs_uvp        (cs_uvp),
  .sw_en         (sw_en),
  .hv_en         (hv_en),
  .dim_src_en    (dim_src_en)
);

// File: tb/pwr_fault_supervisor_bench.sv
module pwr_fault_supervisor_bench;
  localparam int CLK_P   = 10;
  localparam int N_SHORT = 3;
  localparam int WIN     = 20;

  logic clk, rst_n;
  logic sup_above_on, sup_below_off, sup_ovp, aux_ovp, cs_shut, cyc_end, gate_req, cs_uvp, hot;
  logic sw_en, hv_en, dim_src_en;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  pwr_fault_supervisor #(.DSHORT_N(N_SHORT), .DIM_WIN(WIN)) u_pwr_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .sup_above_on(sup_above_on), .sup_below_off(sup_below_off),
    .sup_ovp(sup_ovp), .aux_ovp(aux_ovp), .cs_shut(cs_shut), .cyc_end(cyc_end),
    .gate_req(gate_req), .cs_uvp(cs_uvp), .hot(hot),
    .sw_en(sw_en), .hv_en(hv_en), .dim_src_en(dim_src_en)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic clear_in();
    sup_above_on = 0; sup_below_off = 0; sup_ovp = 0; aux_ovp = 0;
    cs_shut = 0; cyc_end = 0; gate_req = 1; cs_uvp = 0; hot = 0;
  endtask

  // reset, start-up, then a turn-on crossing into run
  task automatic go_run();
    rst_n = 0;
    clear_in();
    tick(); tick();
    rst_n = 1;
    tick();
    sup_above_on = 1;
    tick();
    sup_above_on = 0;
  endtask

  initial begin
    rst_n = 0;
    clear_in();
    tick();
    #1;
    chk("R1 reset sw_en", sw_en, 0);
    chk("R1 reset hv_en", hv_en, 0);
    chk("R1 reset dim", dim_src_en, 0);
    rst_n = 1;
    tick();
    chk("R1 startup hv_en", hv_en, 1);
    chk("R1 startup sw_en", sw_en, 0);
    tick();
    chk("R1 startup waits for turn-on", hv_en, 1);
    sup_above_on = 1;
    tick();
    sup_above_on = 0;
    chk("R1 run sw_en", sw_en, 1);
    chk("R1 run hv_en", hv_en, 0);
    // R10 window: high at turn-on edge, lasts WIN cycles
    chk("R10 dim at turn-on", dim_src_en, 1);
    for (int k = 1; k < WIN; k++) tick();
    chk("R10 dim last cycle", dim_src_en, 1);
    tick();
    chk("R10 dim closed", dim_src_en, 0);

    // R2/R3/R4 sweep of four fault flags in run
    for (int m = 0; m < 16; m++) begin
      go_run();
      sup_below_off = m[0]; sup_ovp = m[1]; aux_ovp = m[2]; hot = m[3];
      #1;
      chk($sformatf("R2 same-cycle gate m=%0d", m), sw_en, (m == 0));
      tick();
      chk($sformatf("R3 next hv m=%0d", m), hv_en, m[0]);
      chk($sformatf("R3 next sw m=%0d", m), sw_en, (m == 0));
      clear_in();
      tick();
      chk($sformatf("R4 restart hv m=%0d", m), hv_en, (m != 0));
    end

    // R4 over-voltage held, then released, run only after turn-on
    go_run();
    sup_ovp = 1;
    tick(); tick();
    chk("R4 ovp held sw", sw_en, 0);
    chk("R4 ovp held hv", hv_en, 0);
    sup_ovp = 0;
    tick();
    chk("R4 ovp released startup", hv_en, 1);
    tick();
    chk("R4 no run without turn-on", sw_en, 0);
    sup_above_on = 1;
    tick();
    sup_above_on = 0;
    chk("R4 back in run", sw_en, 1);
    chk("R10 dim retriggered", dim_src_en, 1);
    sup_below_off = 1;
    tick();
    chk("R10 dim cleared by uvlo", dim_src_en, 0);
    sup_below_off = 0;

    // R5 aux over-voltage recurs at restart
    go_run();
    aux_ovp = 1;
    tick();
    chk("R5 fault wait hv", hv_en, 0);
    sup_below_off = 1;
    tick();
    sup_below_off = 0;
    chk("R5 uvlo restart hv", hv_en, 1);
    sup_above_on = 1;
    tick();
    sup_above_on = 0;
    chk("R5 run re-entered gate low", sw_en, 0);
    tick();
    chk("R5 fault again hv", hv_en, 0);
    aux_ovp = 0;
    tick();
    chk("R5 cleared restart hv", hv_en, 1);

    // R6 diode short confirmation
    go_run();
    for (int k = 0; k < 5; k++) begin
      cyc_end = 1; cs_shut = (k != 2);
      #1;
      chk($sformatf("R6 no trip strobe %0d", k), sw_en, 1);
      tick();
      cyc_end = 0; cs_shut = 0;
    end
    cs_shut = 1;
    tick(); tick();
    chk("R6 flag without strobe ignored", sw_en, 1);
    cyc_end = 1;
    #1;
    chk("R6 third strobe trips same cycle", sw_en, 0);
    tick();
    cyc_end = 0;
    chk("R6 fault wait hv", hv_en, 0);
    chk("R6 fault wait sw", sw_en, 0);
    tick();
    chk("R6 held while flag set", hv_en, 0);
    cs_shut = 0;
    tick();
    chk("R6 restart hv", hv_en, 1);

    // R7 current-sense under-voltage
    go_run();
    gate_req = 0; cs_uvp = 1;
    #1;
    chk("R7 uvp blocks", sw_en, 0);
    tick();
    chk("R7 uvp still blocks", sw_en, 0);
    gate_req = 1; cs_uvp = 0;
    #1;
    chk("R7 held through on time", sw_en, 0);
    tick();
    gate_req = 0;
    #1;
    chk("R7 released", sw_en, 1);
    tick();
    gate_req = 1; cs_uvp = 1;
    #1;
    chk("R7 ignored while gate on", sw_en, 1);
    tick();
    chk("R7 ignored after edge", sw_en, 1);
    cs_uvp = 0;

    // R8 thermal hiccup
    go_run();
    hot = 1;
    #1;
    chk("R8 hot blocks", sw_en, 0);
    tick();
    chk("R8 hiccup entry hv", hv_en, 0);
    sup_below_off = 1;
    tick();
    sup_below_off = 0;
    chk("R8 charge on turn-off", hv_en, 1);
    chk("R8 sw off", sw_en, 0);
    tick();
    chk("R8 charge kept", hv_en, 1);
    sup_above_on = 1;
    tick();
    sup_above_on = 0;
    chk("R8 charge stops at turn-on", hv_en, 0);
    hot = 0;
    tick();
    chk("R8 cooled to startup", hv_en, 1);
    sup_above_on = 1;
    tick();
    sup_above_on = 0;
    chk("R8 run after cool", sw_en, 1);

    // R9 hot at turn-on
    rst_n = 0;
    clear_in();
    tick();
    rst_n = 1;
    tick();
    hot = 1; sup_above_on = 1;
    tick();
    sup_above_on = 0;
    chk("R9 no run when hot", sw_en, 0);
    chk("R9 hiccup hv", hv_en, 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule